// File: doc/BRIEF.md
# Time-of-Day Alarm Matcher

This block decides, once per one-second update, whether the running time of day has reached a programmed alarm time. It looks at three current-time bytes (seconds, minutes, hours) and three alarm bytes. Each alarm byte can be a wildcard that accepts any value. The clock-keeping logic beside it advances the time registers and then pulses `upd_stb` for one cycle. On that cycle the matcher converts all six bytes to plain numbers and compares them.

Bytes are BCD or binary, as `bin_mode` selects. In 12-hour mode the hour bytes carry a PM marker in bit 7, and both hour bytes are mapped onto a 0..23 scale before they are compared. A match sets a sticky flag, whether or not interrupts are enabled. The flag stays set until the owner pulses `flag_clr`. The interrupt qualifier pulses only when the flag is newly set and alarm interrupts are enabled.

Control sits in a two-state machine. `ST_ARMED` means no alarm is pending. `ST_LATCHED` means the flag is set. Its transitions are:
- `SET` (ARMED to LATCHED) on a matching strobe.
- `ACK` (LATCHED to ARMED) on a clear with no matching strobe.
- `REARM` (LATCHED to LATCHED) on a clear and a matching strobe in the same cycle.
- `HOLD` (either state to itself) in every other cycle.

Top module: `tod_alarm_match`

## Requirements
- R1: After reset, `alarm_hit_flag` and `alarm_irq` are both 0.
- R2: When `upd_stb` is high and all three fields are equal after decoding, `alarm_hit_flag` is 1 from the next cycle on.
- R3: With `bin_mode`=0 a byte counts as BCD (upper nibble times ten plus lower nibble), so 0x0A and 0x10 both stand for 10. With `bin_mode`=1 a byte is taken as its binary value.
- R4: An alarm byte whose bits 7 and 6 are both 1 (0xC0..0xFF) accepts any current value, including an hour byte in 12-hour mode. A byte with only one of those bits set is compared as a number.
- R5: With all three alarm bytes wildcarded, every strobe is a match.
- R6: With `h24_mode`=0, the hour is taken from bits 6:0, reduced modulo 12, and raised by 12 when bit 7 (PM) is 1. So 12 AM is hour 0, 12 PM is hour 12, and an alarm hour of 0x13 equals current 0x01. With `h24_mode`=1 the whole byte is decoded.
- R7: Once set, `alarm_hit_flag` stays 1 across later strobes, matching or not, until `flag_clr`.
- R8: The flag is set whatever the value of `alarm_int_en`. `alarm_irq` is a one-cycle pulse, in the same cycle the flag first shows 1, and only when `alarm_int_en` was 1 at the strobe and the flag was not already pending.
- R9: No match is taken without `upd_stb`. Moving the alarm bytes onto the current time leaves the flag at 0.
- R10: A `flag_clr` in the same cycle as a matching strobe leaves the flag at 1 and counts as a new setting, so `alarm_irq` pulses when enabled.
- R11: `flag_clr` with no matching strobe drives the flag to 0 in the next cycle.
- R12: A mismatch in any single non-wildcard field prevents the flag from being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_stb | input | 1 | One-cycle pulse after the time bytes have advanced |
| flag_clr | input | 1 | Acknowledge; clears the pending alarm flag |
| alarm_int_en | input | 1 | Alarm interrupt enable |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| h24_mode | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM in bit 7 |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hour | input | 8 | Alarm hours byte |
| alarm_hit_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | One-cycle interrupt qualifier on a newly set flag |

## Verification
An acknowledge and a matching update can land in the same cycle. The `REARM` transition has to settle that collision without losing the new alarm. The bench provokes it by latching a match first, then raising `flag_clr` and a matching `upd_stb` on the same edge. It judges the result by the flag staying 1 and the interrupt pulsing once. It then repeats the same collision with a non-matching update, where the flag must fall to 0.

// File: rtl/tam_pkg.sv
package tam_pkg;

    localparam int TAM_FIELD_W   = 8;
    localparam int TAM_NIB_W     = TAM_FIELD_W / 2;
    localparam int TAM_NUM_FIELD = 3;
    localparam int TAM_HOUR_IDX  = TAM_NUM_FIELD - 1;
    localparam int TAM_HALF_DAY  = 12;

    typedef logic [TAM_FIELD_W-1:0] tam_field_t;

    typedef enum logic [0:0] {
        ST_ARMED   = 1'b0,
        ST_LATCHED = 1'b1
    } tam_state_e;

    // Top two bits both set: field accepts any value.
    function automatic logic tam_is_wild(input tam_field_t raw);
        return &raw[TAM_FIELD_W-1:TAM_FIELD_W-2];
    endfunction

    // BCD or binary byte to a plain number.
    function automatic tam_field_t tam_decode(input tam_field_t raw, input logic bin_mode);
        tam_field_t tens;
        tam_field_t ones;
        tens = tam_field_t'(raw[TAM_FIELD_W-1:TAM_NIB_W]);
        ones = tam_field_t'(raw[TAM_NIB_W-1:0]);
        if (bin_mode) begin
            return raw;
        end
        return tens * tam_field_t'(10) + ones;
    endfunction

    // Field value on a common scale; hours in 12-hour mode fold onto 0..23.
    function automatic tam_field_t tam_norm(input tam_field_t raw, input logic bin_mode,
                                            input logic h24_mode, input logic is_hour);
        tam_field_t body;
        tam_field_t base;
        if (!is_hour || h24_mode) begin
            return tam_decode(raw, bin_mode);
        end
        body = {1'b0, raw[TAM_FIELD_W-2:0]};
        base = tam_decode(body, bin_mode) % tam_field_t'(TAM_HALF_DAY);
        return raw[TAM_FIELD_W-1] ? base + tam_field_t'(TAM_HALF_DAY) : base;
    endfunction

endpackage

// File: rtl/tam_field_cmp.sv
module tam_field_cmp
    import tam_pkg::*;
#(
    parameter bit IS_HOUR = 1'b0
) (
    input  tam_field_t cur_raw,
    input  tam_field_t alm_raw,
    input  logic       bin_mode,
    input  logic       h24_mode,
    output logic       field_ok
);

    tam_field_t cur_val;
    tam_field_t alm_val;
    logic       alm_wild;

    always_comb begin
        cur_val  = tam_norm(cur_raw, bin_mode, h24_mode, IS_HOUR);
        alm_val  = tam_norm(alm_raw, bin_mode, h24_mode, IS_HOUR);
        alm_wild = tam_is_wild(alm_raw);
        field_ok = alm_wild || (cur_val == alm_val);
    end

endmodule

// File: rtl/tam_match_fsm.sv
module tam_match_fsm
    import tam_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_stb,
    input  logic hit,
    input  logic flag_clr,
    input  logic alarm_int_en,
    output logic alarm_hit_flag,
    output logic alarm_irq
);

    tam_state_e state_q;
    tam_state_e state_d;
    logic       take;
    logic       fresh;

    assign take = upd_stb && hit;

    // Next-state selection: SET, ACK, REARM, HOLD.
    always_comb begin
        state_d = state_q;
        fresh   = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                if (take) begin
                    state_d = ST_LATCHED;           // SET
                    fresh   = 1'b1;
                end
            end
            ST_LATCHED: begin
                if (flag_clr && take) begin
                    state_d = ST_LATCHED;           // REARM
                    fresh   = 1'b1;
                end else if (flag_clr) begin
                    state_d = ST_ARMED;             // ACK
                end
            end
            default: state_d = ST_ARMED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_irq <= 1'b0;
        end else begin
            alarm_irq <= fresh && alarm_int_en;
        end
    end

    assign alarm_hit_flag = (state_q == ST_LATCHED);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_hit_flag && !flag_clr) |=> alarm_hit_flag);

    assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(upd_stb && hit)) |=> !alarm_hit_flag);

    assert_set_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_hit_flag) |-> $past(upd_stb && hit));

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> $past(alarm_int_en && upd_stb && hit));

    assert_irq_with_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> alarm_hit_flag);

    assert_collision_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && upd_stb && hit) |=> alarm_hit_flag);

endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
    import tam_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd_stb,
    input  logic                   flag_clr,
    input  logic                   alarm_int_en,
    input  logic                   bin_mode,
    input  logic                   h24_mode,
    input  logic [TAM_FIELD_W-1:0] cur_sec,
    input  logic [TAM_FIELD_W-1:0] cur_min,
    input  logic [TAM_FIELD_W-1:0] cur_hour,
    input  logic [TAM_FIELD_W-1:0] alm_sec,
    input  logic [TAM_FIELD_W-1:0] alm_min,
    input  logic [TAM_FIELD_W-1:0] alm_hour,
    output logic                   alarm_hit_flag,
    output logic                   alarm_irq
);

    tam_field_t               cur_f [TAM_NUM_FIELD];
    tam_field_t               alm_f [TAM_NUM_FIELD];
    logic [TAM_NUM_FIELD-1:0] field_ok;
    logic                     hit;

    assign cur_f[0] = cur_sec;
    assign cur_f[1] = cur_min;
    assign cur_f[2] = cur_hour;
    assign alm_f[0] = alm_sec;
    assign alm_f[1] = alm_min;
    assign alm_f[2] = alm_hour;

    for (genvar g = 0; g < TAM_NUM_FIELD; g++) begin : g_field
        tam_field_cmp #(
            .IS_HOUR(g == TAM_HOUR_IDX)
        ) i_cmp (
            .cur_raw (cur_f[g]),
            .alm_raw (alm_f[g]),
            .bin_mode(bin_mode),
            .h24_mode(h24_mode),
            .field_ok(field_ok[g])
        );
    end

    assign hit = &field_ok;

    tam_match_fsm i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .upd_stb       (upd_stb),
        .hit           (hit),
        .flag_clr      (flag_clr),
        .alarm_int_en  (alarm_int_en),
        .alarm_hit_flag(alarm_hit_flag),
        .alarm_irq     (alarm_irq)
    );

endmodule

// File: tb/test_tod_alarm_match.sv
`timescale 1ns/1ps
module test_tod_alarm_match;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_stb = 1'b0;
    logic       flag_clr = 1'b0;
    logic       alarm_int_en = 1'b0;
    logic       bin_mode = 1'b0;
    logic       h24_mode = 1'b1;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
    logic [7:0] alm_sec = '0, alm_min = '0, alm_hour = '0;
    logic       alarm_hit_flag, alarm_irq;

    int applied = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tod_alarm_match i_tod_alarm_match (
        .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .flag_clr(flag_clr),
        .alarm_int_en(alarm_int_en), .bin_mode(bin_mode), .h24_mode(h24_mode),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .alarm_hit_flag(alarm_hit_flag), .alarm_irq(alarm_irq)
    );

    // {cs, cm, ch, as, am, ah, bin, h24, expect}
    localparam int NV = 19;
    localparam logic [50:0] VEC [NV] = '{
        {8'h30, 8'h15, 8'h10, 8'h30, 8'h15, 8'h10, 1'b0, 1'b1, 1'b1}, // R2
        {8'h30, 8'h15, 8'h10, 8'h31, 8'h15, 8'h10, 1'b0, 1'b1, 1'b0}, // R12
        {8'h30, 8'h15, 8'h10, 8'h30, 8'h16, 8'h10, 1'b0, 1'b1, 1'b0}, // R12
        {8'h30, 8'h15, 8'h10, 8'h30, 8'h15, 8'h11, 1'b0, 1'b1, 1'b0}, // R12
        {8'h42, 8'h15, 8'h10, 8'hC5, 8'h15, 8'h10, 1'b0, 1'b1, 1'b1}, // R4
        {8'h42, 8'h15, 8'h10, 8'h42, 8'hD9, 8'h10, 1'b0, 1'b1, 1'b1}, // R4
        {8'h42, 8'h15, 8'h10, 8'h42, 8'h15, 8'hFF, 1'b0, 1'b1, 1'b1}, // R4
        {8'h17, 8'h48, 8'h23, 8'hFF, 8'hC0, 8'hD3, 1'b0, 1'b1, 1'b1}, // R5
        {8'h0A, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1}, // R3
        {8'h0A, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0}, // R3
        {8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1}, // R6
        {8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0}, // R6
        {8'h00, 8'h00, 8'h0C, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1}, // R6
        {8'h00, 8'h00, 8'h92, 8'h00, 8'h00, 8'h12, 1'b0, 1'b0, 1'b0}, // R6
        {8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0}, // R6
        {8'h00, 8'h00, 8'h81, 8'h00, 8'h00, 8'h13, 1'b0, 1'b0, 1'b0}, // R6
        {8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h13, 1'b0, 1'b0, 1'b1}, // R6
        {8'h00, 8'h00, 8'h00, 8'hBF, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0}, // R4
        {8'h00, 8'h00, 8'h85, 8'h00, 8'h00, 8'hC1, 1'b0, 1'b0, 1'b1}  // R4
    };

    task automatic check(input logic got, input logic exp, input string req);
        applied++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic step(input logic stb, input logic clr);
        upd_stb  = stb;
        flag_clr = clr;
        @(posedge clk);
        @(negedge clk);
        upd_stb  = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] cs, cm, ch, as_, am, ah);
        cur_sec = cs; cur_min = cm; cur_hour = ch;
        alm_sec = as_; alm_min = am; alm_hour = ah;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(alarm_hit_flag, 1'b0, "R1 flag");
        check(alarm_irq, 1'b0, "R1 irq");

        // Vector table: clear, then one strobe with interrupts enabled.
        alarm_int_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            set_time(VEC[i][50:43], VEC[i][42:35], VEC[i][34:27],
                     VEC[i][26:19], VEC[i][18:11], VEC[i][10:3]);
            bin_mode = VEC[i][2];
            h24_mode = VEC[i][1];
            step(1'b0, 1'b1);
            step(1'b1, 1'b0);
            check(alarm_hit_flag, VEC[i][0], $sformatf("R2/R3/R4/R6/R12 vec %0d flag", i));
            check(alarm_irq, VEC[i][0], $sformatf("R8 vec %0d irq", i));
        end

        // R9: alarm moved onto current time without a strobe.
        bin_mode = 1'b0; h24_mode = 1'b1;
        set_time(8'h05, 8'h06, 8'h07, 8'h00, 8'h00, 8'h00);
        step(1'b0, 1'b1);
        set_time(8'h05, 8'h06, 8'h07, 8'h05, 8'h06, 8'h07);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        check(alarm_hit_flag, 1'b0, "R9 no strobe no flag");

        // R8: flag set with interrupts disabled, no irq.
        alarm_int_en = 1'b0;
        step(1'b1, 1'b0);
        check(alarm_hit_flag, 1'b1, "R8 flag without enable");
        check(alarm_irq, 1'b0, "R8 irq masked");

        // R7: sticky over a mismatching strobe and over a matching one.
        alarm_int_en = 1'b1;
        set_time(8'h06, 8'h06, 8'h07, 8'h05, 8'h06, 8'h07);
        step(1'b1, 1'b0);
        check(alarm_hit_flag, 1'b1, "R7 sticky on mismatch");
        set_time(8'h05, 8'h06, 8'h07, 8'h05, 8'h06, 8'h07);
        step(1'b1, 1'b0);
        check(alarm_hit_flag, 1'b1, "R7 sticky on match");
        check(alarm_irq, 1'b0, "R8 no irq when already pending");

        // R10: clear and matching strobe in one cycle.
        step(1'b1, 1'b1);
        check(alarm_hit_flag, 1'b1, "R10 collision keeps flag");
        check(alarm_irq, 1'b1, "R10 collision raises irq");
        step(1'b0, 1'b0);
        check(alarm_irq, 1'b0, "R8 irq is one cycle");

        // R11: clear with a mismatching strobe, then clear alone.
        set_time(8'h09, 8'h06, 8'h07, 8'h05, 8'h06, 8'h07);
        step(1'b1, 1'b1);
        check(alarm_hit_flag, 1'b0, "R11 clear beats mismatch");
        set_time(8'h05, 8'h06, 8'h07, 8'h05, 8'h06, 8'h07);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        check(alarm_hit_flag, 1'b0, "R11 clear alone");

        // R5: all wild fires on each of several different updates.
        for (int k = 0; k < 3; k++) begin
            set_time(8'(k * 7), 8'(k + 1), 8'(k + 2), 8'hC0, 8'hE1, 8'hFF);
            step(1'b1, 1'b0);
            check(alarm_hit_flag, 1'b1, $sformatf("R5 every update %0d", k));
            step(1'b0, 1'b1);
        end

        finish_run();
    end

endmodule